// File: doc/BRIEF.md
# Multi-Channel PWM Generator with Selectable Prescaler

This peripheral produces up to eight independent pulse-width-modulated outputs behind a plain 32-bit register bus. It uses a single clock. Each channel counts prescaled ticks through a programmable period and compares the count with a duty threshold to drive its pin. Two tick sources arrive as one-cycle enable pulses: a fast one, and a slow one that the system generates 1625 times slower. Each channel picks one of them and divides it further by a power of two.

Software programs a channel through three registers in that channel's window: control, period and threshold. It then starts the channel by setting the channel's bit in a shared enable word. A running channel takes new settings only at the end of a period. Software may therefore rewrite a live channel without producing a shortened or glitched cycle.

Top module: `pwm_multi`

## Requirements
- R1: The enable word is at byte address 0x000. Bit n starts (1) or stops (0) channel n. Writing it changes no other channel state, and reading it returns the mask in bits [NUM_CH-1:0] with zeros above.
- R2: Channel n owns the window starting at 0x080 + 0x40*n. Inside the window, control is at +0x00, period at +0x2C and threshold at +0x30. Control reads back only bits 15, 3 and [2:0]. Every other offset reads as zero.
- R3: Period and threshold keep only their low 13 bits. After all-ones is written to period, it reads back 0x1FFF.
- R4: With exponent N in control[2:0], the channel count advances once per 2^N selected ticks. It runs 0 .. P-1 and then returns to 0.
- R5: When control bit 3 is 1, the channel counts `slow_tick_i` pulses. When it is 0, the channel counts `fast_tick_i` pulses.
- R6: The output is high exactly while count < threshold. A threshold of 0 keeps the output low, and a threshold of P or more keeps it high.
- R7: Control, period and threshold written to a running channel take effect at the next return to 0. A write that lands on the same edge as that return takes effect one period later.
- R8: A stopped channel drives low and clears its count and prescaler. After its enable bit is set, the first cycle shows count 0 with the current settings.
- R9: A channel whose active control has bit 15 clear behaves as stopped even when its enable bit is set.
- R10: A period of 0 returns the count to 0 on every step. The output is then constantly high for threshold > 0 and constantly low for threshold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for bus and channels |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_tick_i | input | 1 | One-cycle pulse per fast tick |
| slow_tick_i | input | 1 | One-cycle pulse per slow tick (1625x slower) |
| bus_we_i | input | 1 | Write strobe for the current address |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| pwm_o | output | NUM_CH | One PWM output per channel |

## Verification
The critical collision is a bus write to a running channel's period or threshold on the same clock edge where that channel's count returns to 0. At that edge the active copy must take the value that was in the shadow before the write, and the new value must wait for the following period. The bench triggers this by repeating one rewrite at every cycle offset across more than a full period, so one of the runs lands exactly on the wrap edge. A cycle-stepped model in the bench, which applies the step before the write on each edge, judges the pin on every cycle. A second collision, an enable-word write while another channel is mid-period, is judged the same way on the untouched channel's output.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int BUS_W         = 32;
  localparam int PER_W         = 13;
  localparam int DIV_W         = 3;
  localparam int PRE_W         = (1 << DIV_W) - 1;
  localparam int WIN_BASE      = 32'h80;
  localparam int WIN_LSB       = 6;
  localparam int OFF_CTRL      = 6'h00;
  localparam int OFF_PER       = 6'h2C;
  localparam int OFF_THR       = 6'h30;
  localparam int CTRL_MODE_BIT = 15;
  localparam int CTRL_SLOW_BIT = 3;

  typedef struct packed {
    logic             mode;
    logic             slow;
    logic [DIV_W-1:0] div;
    logic [PER_W-1:0] per;
    logic [PER_W-1:0] thr;
  } chan_cfg_t;
endpackage

// File: rtl/pwm_regbank.sv
module pwm_regbank
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [BUS_W-1:0]       wdata_i,
  output logic [BUS_W-1:0]       rdata_o,
  output logic [NUM_CH-1:0]      en_o,
  output chan_cfg_t [NUM_CH-1:0] cfg_o
);
  localparam int IDX_W = ADDR_W - WIN_LSB;

  logic              en_hit;
  logic              win_hit;
  logic [ADDR_W-1:0] rel;
  logic [IDX_W-1:0]  idx;
  logic [WIN_LSB-1:0] off;

  assign en_hit  = (addr_i == '0);
  assign rel     = addr_i - ADDR_W'(WIN_BASE);
  assign idx     = rel[ADDR_W-1:WIN_LSB];
  assign off     = addr_i[WIN_LSB-1:0];
  assign win_hit = (addr_i >= ADDR_W'(WIN_BASE)) &&
                   ({1'b0, idx} < (IDX_W+1)'(NUM_CH));

  // shared enable word
  logic [NUM_CH-1:0] en_q, en_d;

  always_comb begin
    en_d = en_q;
    if (we_i && en_hit) en_d = wdata_i[NUM_CH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  assign en_o = en_q;

  // per-channel shadow registers
  logic [NUM_CH-1:0] mode_q, slow_q;
  logic [DIV_W-1:0]  div_q [NUM_CH];
  logic [PER_W-1:0]  per_q [NUM_CH];
  logic [PER_W-1:0]  thr_q [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_win
    logic             hit;
    logic             mode_d, slow_d;
    logic [DIV_W-1:0] div_d;
    logic [PER_W-1:0] per_d, thr_d;

    assign hit = we_i && win_hit && (idx == IDX_W'(c));

    always_comb begin
      mode_d = mode_q[c];
      slow_d = slow_q[c];
      div_d  = div_q[c];
      per_d  = per_q[c];
      thr_d  = thr_q[c];
      if (hit && off == WIN_LSB'(OFF_CTRL)) begin
        mode_d = wdata_i[CTRL_MODE_BIT];
        slow_d = wdata_i[CTRL_SLOW_BIT];
        div_d  = wdata_i[DIV_W-1:0];
      end
      if (hit && off == WIN_LSB'(OFF_PER)) per_d = wdata_i[PER_W-1:0];
      if (hit && off == WIN_LSB'(OFF_THR)) thr_d = wdata_i[PER_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q[c] <= 1'b0;
        slow_q[c] <= 1'b0;
        div_q[c]  <= '0;
        per_q[c]  <= '0;
        thr_q[c]  <= '0;
      end else begin
        mode_q[c] <= mode_d;
        slow_q[c] <= slow_d;
        div_q[c]  <= div_d;
        per_q[c]  <= per_d;
        thr_q[c]  <= thr_d;
      end
    end

    assign cfg_o[c] = '{mode: mode_q[c], slow: slow_q[c], div: div_q[c],
                        per: per_q[c], thr: thr_q[c]};
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    if (en_hit) rdata_o[NUM_CH-1:0] = en_q;
    for (int c = 0; c < NUM_CH; c++) begin
      if (win_hit && idx == IDX_W'(c)) begin
        if (off == WIN_LSB'(OFF_CTRL)) begin
          rdata_o[CTRL_MODE_BIT] = mode_q[c];
          rdata_o[CTRL_SLOW_BIT] = slow_q[c];
          rdata_o[DIV_W-1:0]     = div_q[c];
        end
        if (off == WIN_LSB'(OFF_PER)) rdata_o[PER_W-1:0] = per_q[c];
        if (off == WIN_LSB'(OFF_THR)) rdata_o[PER_W-1:0] = thr_q[c];
      end
    end
  end

  assert_enable_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && en_hit) |=> (en_o == $past(wdata_i[NUM_CH-1:0])));

  assert_enable_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_i && en_hit) |=> $stable(en_o));

  always_comb begin
    if (rst_n === 1'b1 && win_hit && off == WIN_LSB'(OFF_PER))
      assert_period_mask_R3: assert (rdata_o[BUS_W-1:PER_W] == '0);
  end
endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             slow_sel_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             fast_tick_i,
  input  logic             slow_tick_i,
  output logic             step_o
);
  logic [PRE_W-1:0] pre_q, pre_d, mask;
  logic             tick;

  assign tick   = slow_sel_i ? slow_tick_i : fast_tick_i;
  assign mask   = PRE_W'((PRE_W+1)'(1) << div_i) - PRE_W'(1);
  assign step_o = run_i && tick && (pre_q == mask);

  always_comb begin
    pre_d = pre_q;
    if (!run_i)      pre_d = '0;
    else if (step_o) pre_d = '0;
    else if (tick)   pre_d = pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assert_step_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |-> (slow_sel_i ? slow_tick_i : fast_tick_i));

  assert_no_divide_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (div_i == '0) |-> (pre_q == '0));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en_i,
  input  chan_cfg_t cfg_i,
  input  logic      fast_tick_i,
  input  logic      slow_tick_i,
  output logic      pwm_o
);
  chan_cfg_t        act_q, act_d;
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic             run, step, wrap;

  assign run = en_i && act_q.mode;

  pwm_prescale u_pre (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run),
    .slow_sel_i (act_q.slow),
    .div_i      (act_q.div),
    .fast_tick_i(fast_tick_i),
    .slow_tick_i(slow_tick_i),
    .step_o     (step)
  );

  assign wrap = step && ((act_q.per == '0) ||
                ((PER_W+1)'(cnt_q) + (PER_W+1)'(1) >= (PER_W+1)'(act_q.per)));

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (!run || wrap) begin
      cnt_d = '0;
      act_d = cfg_i;
    end else if (step) begin
      cnt_d = cnt_q + PER_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign pwm_o = run && (cnt_q < act_q.thr);

  assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q.per != '0) |-> (cnt_q < act_q.per));

  assert_idle_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

  assert_hold_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(act_q));

  assert_zero_thr_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q.thr == '0) |-> !pwm_o);

  assert_no_mode_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q.mode |-> !pwm_o);
endmodule

// File: rtl/pwm_multi.sv
module pwm_multi
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_tick_i,
  input  logic              slow_tick_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  logic [NUM_CH-1:0]      en;
  chan_cfg_t [NUM_CH-1:0] cfg;

  pwm_regbank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (bus_we_i),
    .addr_i (bus_addr_i),
    .wdata_i(bus_wdata_i),
    .rdata_o(bus_rdata_o),
    .en_o   (en),
    .cfg_o  (cfg)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_chan u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (en[c]),
      .cfg_i      (cfg[c]),
      .fast_tick_i(fast_tick_i),
      .slow_tick_i(slow_tick_i),
      .pwm_o      (pwm_o[c])
    );
  end

  assert_stopped_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> (pwm_o == '0));
endmodule

// File: tb/tb_pwm_multi.sv
module tb_pwm_multi;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ft, st, we;
  logic [9:0]  addr;
  logic [31:0] wdata, rdata;
  logic [7:0]  pwm;

  pwm_multi #(.NUM_CH(8), .ADDR_W(10)) dut (
    .clk(clk), .rst_n(rst_n), .fast_tick_i(ft), .slow_tick_i(st),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .pwm_o(pwm)
  );

  always #4 clk = ~clk;

  int    n_cmp = 0, n_bad = 0, cyc = 0;
  bit    ft_pat = 0, done = 0;
  string tag = "R8";

  // bench model of channels 0 and 1
  bit m_en[2], sh_mode[2], sh_slow[2], a_mode[2], a_slow[2];
  int sh_div[2], sh_per[2], sh_thr[2], a_div[2], a_per[2], a_thr[2];
  int m_cnt[2], m_pre[2];

  function automatic int ctrl_a(int c); return 32'h80 + 32'h40 * c; endfunction
  function automatic int per_a(int c);  return ctrl_a(c) + 32'h2C; endfunction
  function automatic int thr_a(int c);  return ctrl_a(c) + 32'h30; endfunction

  function automatic bit exp_out(int c);
    return m_en[c] && a_mode[c] && (m_cnt[c] < a_thr[c]);
  endfunction

  function automatic void load(int c);
    a_mode[c] = sh_mode[c]; a_slow[c] = sh_slow[c]; a_div[c] = sh_div[c];
    a_per[c] = sh_per[c]; a_thr[c] = sh_thr[c];
  endfunction

  function automatic void model_edge(bit f, bit s);
    for (int c = 0; c < 2; c++) begin
      if (!(m_en[c] && a_mode[c])) begin
        m_cnt[c] = 0; m_pre[c] = 0; load(c);
      end else if (a_slow[c] ? s : f) begin
        if (m_pre[c] == (1 << a_div[c]) - 1) begin
          m_pre[c] = 0;
          if (a_per[c] == 0 || m_cnt[c] + 1 >= a_per[c]) begin
            m_cnt[c] = 0; load(c);
          end else m_cnt[c]++;
        end else m_pre[c]++;
      end
    end
  endfunction

  function automatic void model_write(int a, logic [31:0] d);
    if (a == 0) begin m_en[0] = d[0]; m_en[1] = d[1]; end
    for (int c = 0; c < 2; c++) begin
      if (a == ctrl_a(c)) begin
        sh_mode[c] = d[15]; sh_slow[c] = d[3]; sh_div[c] = int'(d[2:0]);
      end
      if (a == per_a(c)) sh_per[c] = int'(d[12:0]);
      if (a == thr_a(c)) sh_thr[c] = int'(d[12:0]);
    end
  endfunction

  task automatic check(bit ok, string what, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc_go(bit w, int a, logic [31:0] d, bit rchk, logic [31:0] rexp);
    @(negedge clk);
    for (int c = 0; c < 2; c++)
      check(pwm[c] == exp_out(c), $sformatf("pwm[%0d]", c), pwm[c], exp_out(c));
    check(pwm[7:2] == 6'd0, "pwm[7:2] of unused channels", pwm[7:2], 0);
    ft = ft_pat ? (cyc % 3 != 2) : 1'b1;
    st = (cyc % 7 == 0);
    we = w; addr = a[9:0]; wdata = d;
    if (rchk) begin
      #1;
      check(rdata == rexp, $sformatf("readback @%0h", a), rdata, rexp);
    end
    @(posedge clk);
    cyc++;
    model_edge(ft, st);
    if (w) model_write(a, d);
  endtask

  task automatic wr(int a, logic [31:0] d); cyc_go(1'b1, a, d, 1'b0, 32'd0); endtask
  task automatic rd(int a, logic [31:0] e); cyc_go(1'b0, a, 32'd0, 1'b1, e); endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc_go(1'b0, 0, 32'd0, 1'b0, 32'd0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog (all R): actual running expected finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; ft = 1'b1; st = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // reset state, R8 and R1
    tag = "R8 reset";
    check(pwm == 8'd0, "pwm after reset", pwm, 0);
    tag = "R1 reset";
    rd(0, 32'd0);

    // register layout and masking: R2, R3
    tag = "R3";
    wr(per_a(0), 32'hFFFF_FFFF);  rd(per_a(0), 32'h1FFF);
    wr(thr_a(1), 32'h000A_BCDE);  rd(thr_a(1), 32'h000A_BCDE & 32'h1FFF);
    tag = "R2";
    wr(ctrl_a(1), 32'hFFFF_FFFF); rd(ctrl_a(1), 32'h800F);
    wr(ctrl_a(7), 32'h0000_8005); rd(ctrl_a(7), 32'h8005);
    rd(ctrl_a(1) + 4, 32'd0);
    wr(ctrl_a(7), 32'd0);         rd(ctrl_a(7), 32'd0);
    wr(ctrl_a(1), 32'd0);

    // period / prescaler / threshold sweep: R4, R6, R8
    tag = "R4 R6 R8 sweep";
    for (int n = 0; n < 3; n++)
      for (int pi = 0; pi < 3; pi++)
        for (int ti = 0; ti < 5; ti++) begin
          int p, t;
          p = 1 + 2 * pi;
          t = (ti == 0) ? 0 : (ti == 1) ? 1 : (ti == 2) ? p - 1 : (ti == 3) ? p : p + 2;
          ft_pat = (pi == 1);
          wr(ctrl_a(0), 32'h8000 | n);
          wr(per_a(0), p);
          wr(thr_a(0), t);
          wr(0, 32'h1);
          idle(p * (1 << n) * 3 + 3);
          wr(0, 32'h0);
          idle(1);
        end

    // clock source select: R5 (ch0 slow, ch1 fast, both live)
    tag = "R5";
    ft_pat = 1;
    for (int n = 0; n < 2; n++) begin
      wr(ctrl_a(0), 32'h8008 | n); wr(per_a(0), 3); wr(thr_a(0), 1);
      wr(ctrl_a(1), 32'h8001);     wr(per_a(1), 4); wr(thr_a(1), 2);
      wr(0, 32'h3);
      idle(3 * (1 << n) * 7 * 2 + 5);
      wr(0, 32'h0);
      idle(1);
    end

    // run-mode bit clear: R9
    tag = "R9";
    wr(ctrl_a(0), 32'h0002); wr(per_a(0), 4); wr(thr_a(0), 2);
    wr(0, 32'h1); idle(20); wr(0, 32'h0); idle(1);

    // zero period: R10
    tag = "R10";
    ft_pat = 0;
    wr(ctrl_a(0), 32'h8000); wr(per_a(0), 0); wr(thr_a(0), 1);
    wr(0, 32'h1); idle(8);
    wr(thr_a(0), 0); idle(8);
    wr(0, 32'h0); idle(1);

    // live rewrite swept over every offset, incl. the wrap edge: R7
    tag = "R7";
    for (int off = 0; off < 12; off++) begin
      wr(ctrl_a(0), 32'h8000); wr(per_a(0), 6); wr(thr_a(0), 3);
      wr(ctrl_a(1), 32'h8001); wr(per_a(1), 3); wr(thr_a(1), 1);
      wr(0, 32'h3);
      idle(off);
      wr(per_a(0), 4);
      wr(thr_a(0), 1);
      wr(ctrl_a(0), 32'h8001);
      idle(20);
      wr(0, 32'h0);
      idle(1);
    end

    // enable word independence: R1
    tag = "R1";
    ft_pat = 1;
    wr(ctrl_a(0), 32'h8000); wr(per_a(0), 5); wr(thr_a(0), 3);
    wr(ctrl_a(1), 32'h8001); wr(per_a(1), 5); wr(thr_a(1), 2);
    wr(0, 32'h2);  idle(7);
    wr(0, 32'h3);  idle(9);
    rd(0, 32'h3);
    wr(0, 32'h83); rd(0, 32'h83); idle(6);
    wr(0, 32'h82); idle(9);
    wr(0, 32'h0);  idle(3);
    rd(0, 32'h0);

    done = 1;
    finish_run();
  end
endmodule